// File: doc/BRIEF.md
# Memory-Mapped 16-Pin GPIO Port Controller

This block controls one sixteen-pin general-purpose I/O port. Software reaches it through a simple single-cycle register bus with a select, a write flag, a byte offset and a transfer-size bit. Inside it keeps a function-enable mask, a data register, an input-enable mask, a 32-bit pin-mux word and a direction mask. The direction mask cannot be written directly. It changes only through a set alias and a clear alias, and the data register also has atomic set and clear aliases.

When software changes the data or sets direction bits, the block announces an output update. It raises a one-cycle strobe and presents the full level vector with a drive-enable mask. The drive-enable mask is the inverse of input enable. Incoming pin levels pass through a per-pin qualifier: a pin counts as a listening input only when its direction bit is 0, its input enable is 1 and its function enable is 1. A change on a qualifying pin is forwarded with a one-cycle valid pulse. Accesses of the wrong size, and accesses to offsets outside the register window, are refused and flagged.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset every register reads 0, and out_stb, out_level, out_drive_en, in_level, in_valid, bus_rdata and bus_err are all 0.
- R2: Byte offsets 0x18 (input enable), 0x00 (function enable), 0x04 (data) and 0x1C (mux) are written directly and read back directly. A read returns its value on bus_rdata in the cycle after the access. 16-bit registers are zero-extended to 32 bits.
- R3: Writing offset 0x08 ORs the low 16 write bits into data. Writing offset 0x0C clears every data bit that is 1 in the write value. Reads at 0x04, 0x08 and 0x0C all return data.
- R4: Writing offset 0x10 ORs the value into the direction mask, and writing offset 0x14 clears the direction bits that are 1 in the value. Reads at 0x10 and 0x14 both return the direction mask. There is no direct write path to the direction mask.
- R5: Offset 0x1C requires bus_size=1 (32-bit). Every other offset requires bus_size=0 (16-bit). A wrong-size access changes no state and returns bus_rdata=0. It raises bus_err for one cycle, in the cycle after the access.
- R6: Any offset that is not a multiple of 4, or that is 0x20 or above, is invalid. Such an access raises bus_err for one cycle, in the cycle after the access, returns bus_rdata=0 and changes no state.
- R7: A valid write to offset 0x04, 0x08, 0x0C or 0x10 raises out_stb for exactly one cycle, in the cycle after the write. At the same time out_level shows the updated data and out_drive_en shows the inverse of input enable. A write to any other offset raises no strobe.
- R8: If pin i has direction 0, input enable 1 and function enable 1, then a change of pin_in[i] sets in_valid[i] for one cycle, in the following cycle, and in_level[i] then holds the new level.
- R9: A change on a pin that fails any of the three R8 conditions leaves its in_valid bit at 0 and its in_level bit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte offset from the block base |
| bus_size | input | 1 | 0 = 16-bit transfer, 1 = 32-bit transfer |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| bus_err | output | 1 | One-cycle error pulse for a bad size or offset |
| pin_in | input | 16 | Incoming pin levels, already synchronous to clk |
| out_stb | output | 1 | One-cycle output update strobe |
| out_level | output | 16 | Output level vector, updated on out_stb |
| out_drive_en | output | 16 | Per-pin drive enable, updated on out_stb |
| in_level | output | 16 | Last forwarded level of each pin |
| in_valid | output | 16 | Per-pin pulse marking a forwarded change |

## Verification
The assertions take for granted that pin_in is already synchronous to clk. They also assume that bus_sel lasts one cycle per access, so that every response or strobe can be tied to the access in the cycle before it. The stimulus drives every input half a cycle away from the active edge. It keeps pin changes and bus accesses in separate cycles, so the qualifying masks are stable when a pin edge is judged. The size and offset error cases are issued on their own, with a read-back afterwards showing that no register moved.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  typedef enum logic [2:0] {
    RG_FUNC = 3'd0,
    RG_DATA = 3'd1,
    RG_DSET = 3'd2,
    RG_DCLR = 3'd3,
    RG_OSET = 3'd4,
    RG_OCLR = 3'd5,
    RG_INEN = 3'd6,
    RG_MUX  = 3'd7
  } reg_idx_e;

  localparam logic SZ_HALF = 1'b0;
  localparam logic SZ_WORD = 1'b1;

endpackage

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int PINS   = 16,
  parameter int MUX_W  = 32,
  parameter int BUS_W  = 32,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic              size,
  input  logic [BUS_W-1:0]  wdata,
  output logic [BUS_W-1:0]  rdata,
  output logic              err,
  output logic [PINS-1:0]   fer_q,
  output logic [PINS-1:0]   dir_q,
  output logic [PINS-1:0]   inen_q,
  output logic [PINS-1:0]   data_nxt,
  output logic              upd_fire
);

  localparam int WIN_BITS = 5;

  reg_idx_e         idx;
  logic             in_range;
  logic             size_ok;
  logic             acc_ok;
  logic             wr_ok;
  logic [PINS-1:0]  wv;
  logic [PINS-1:0]  data_q;
  logic [PINS-1:0]  dir_nxt;
  logic [MUX_W-1:0] mux_q;
  logic [BUS_W-1:0] rd_val;

  assign idx      = reg_idx_e'(addr[4:2]);
  assign in_range = (addr[1:0] == 2'b00) && ((addr >> WIN_BITS) == '0);
  assign size_ok  = (idx == RG_MUX) ? (size == SZ_WORD) : (size == SZ_HALF);
  assign acc_ok   = sel && in_range && size_ok;
  assign wr_ok    = acc_ok && wr;
  assign wv       = wdata[PINS-1:0];

  always_comb begin
    data_nxt = data_q;
    dir_nxt  = dir_q;
    if (wr_ok) begin
      case (idx)
        RG_DATA: data_nxt = wv;
        RG_DSET: data_nxt = data_q | wv;
        RG_DCLR: data_nxt = data_q & ~wv;
        RG_OSET: dir_nxt  = dir_q | wv;
        RG_OCLR: dir_nxt  = dir_q & ~wv;
        default: ;
      endcase
    end
  end

  assign upd_fire = wr_ok && (idx == RG_DATA || idx == RG_DSET ||
                              idx == RG_DCLR || idx == RG_OSET);

  always_comb begin
    case (idx)
      RG_FUNC:                   rd_val = BUS_W'(fer_q);
      RG_DATA, RG_DSET, RG_DCLR: rd_val = BUS_W'(data_q);
      RG_OSET, RG_OCLR:          rd_val = BUS_W'(dir_q);
      RG_INEN:                   rd_val = BUS_W'(inen_q);
      default:                   rd_val = BUS_W'(mux_q);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fer_q  <= '0;
      data_q <= '0;
      dir_q  <= '0;
      inen_q <= '0;
      mux_q  <= '0;
      rdata  <= '0;
      err    <= 1'b0;
    end else begin
      data_q <= data_nxt;
      dir_q  <= dir_nxt;
      if (wr_ok && idx == RG_FUNC) fer_q  <= wv;
      if (wr_ok && idx == RG_INEN) inen_q <= wv;
      if (wr_ok && idx == RG_MUX)  mux_q  <= wdata[MUX_W-1:0];
      rdata <= (acc_ok && !wr) ? rd_val : '0;
      err   <= sel && !(in_range && size_ok);
    end
  end

  // R5: a wrong-size access to a mapped offset is flagged next cycle
  p_bad_size_r5: assert property (@(posedge clk) disable iff (rst)
    (sel && in_range && !size_ok) |=> err);

  // R6: an error response never carries data
  p_err_zero_r6: assert property (@(posedge clk) disable iff (rst)
    err |-> (rdata == '0));

  // R3: after a set-alias write every written one is present in data
  p_set_or_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_ok && idx == RG_DSET) |=> ((data_q & $past(wv)) == $past(wv)));

  // R4: after a direction-clear write no written one survives
  p_dir_clr_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_ok && idx == RG_OCLR) |=> ((dir_q & $past(wv)) == '0));

endmodule

// File: rtl/gpio_port_drive.sv
module gpio_port_drive #(
  parameter int PINS = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            fire,
  input  logic [PINS-1:0] data_nxt,
  input  logic [PINS-1:0] inen_q,
  output logic            out_stb,
  output logic [PINS-1:0] out_level,
  output logic [PINS-1:0] out_drive_en
);

  always_ff @(posedge clk) begin
    if (rst) out_stb <= 1'b0;
    else     out_stb <= fire;
  end

  for (genvar i = 0; i < PINS; i++) begin : g_pin
    always_ff @(posedge clk) begin
      if (rst) begin
        out_level[i]    <= 1'b0;
        out_drive_en[i] <= 1'b0;
      end else if (fire) begin
        out_level[i]    <= data_nxt[i];
        out_drive_en[i] <= !inen_q[i];
      end
    end
  end

  // R7: the strobe never lasts two cycles without a second update
  p_stb_single_r7: assert property (@(posedge clk) disable iff (rst)
    (out_stb && !fire) |=> !out_stb);

  // R7: level and enables hold between updates
  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !fire |=> ($stable(out_level) && $stable(out_drive_en)));

endmodule

// File: rtl/gpio_port_sense.sv
module gpio_port_sense #(
  parameter int PINS = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PINS-1:0] pin_in,
  input  logic [PINS-1:0] dir_q,
  input  logic [PINS-1:0] inen_q,
  input  logic [PINS-1:0] fer_q,
  output logic [PINS-1:0] in_level,
  output logic [PINS-1:0] in_valid
);

  logic [PINS-1:0] pin_prev;
  logic [PINS-1:0] qual;

  assign qual = ~dir_q & inen_q & fer_q;

  for (genvar i = 0; i < PINS; i++) begin : g_pin
    logic hit;
    assign hit = qual[i] && (pin_in[i] != pin_prev[i]);

    always_ff @(posedge clk) begin
      if (rst) begin
        pin_prev[i] <= 1'b0;
        in_level[i] <= 1'b0;
        in_valid[i] <= 1'b0;
      end else begin
        pin_prev[i] <= pin_in[i];
        in_valid[i] <= hit;
        if (hit) in_level[i] <= pin_in[i];
      end
    end
  end

  // R9: no valid pulse on a pin that was blocked in the previous cycle
  p_block_r9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((in_valid & $past(~qual)) == '0));

  // R8: a valid pulse carries the level the pin had when it was seen
  p_level_r8: assert property (@(posedge clk) disable iff (rst)
    (in_valid != '0) |-> ((in_level & in_valid) == ($past(pin_in) & in_valid)));

endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl #(
  parameter int PINS   = 16,
  parameter int MUX_W  = 32,
  parameter int BUS_W  = 32,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_size,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              bus_err,
  input  logic [PINS-1:0]   pin_in,
  output logic              out_stb,
  output logic [PINS-1:0]   out_level,
  output logic [PINS-1:0]   out_drive_en,
  output logic [PINS-1:0]   in_level,
  output logic [PINS-1:0]   in_valid
);

  localparam logic [ADDR_W-1:0] OFS_DATA = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] OFS_OCLR = ADDR_W'(20);

  logic [PINS-1:0] fer_q;
  logic [PINS-1:0] dir_q;
  logic [PINS-1:0] inen_q;
  logic [PINS-1:0] data_nxt;
  logic            upd_fire;

  gpio_port_regs #(
    .PINS(PINS), .MUX_W(MUX_W), .BUS_W(BUS_W), .ADDR_W(ADDR_W)
  ) i_regs (
    .clk(clk), .rst(rst), .sel(bus_sel), .wr(bus_wr), .addr(bus_addr),
    .size(bus_size), .wdata(bus_wdata), .rdata(bus_rdata), .err(bus_err),
    .fer_q(fer_q), .dir_q(dir_q), .inen_q(inen_q),
    .data_nxt(data_nxt), .upd_fire(upd_fire)
  );

  gpio_port_drive #(.PINS(PINS)) i_drive (
    .clk(clk), .rst(rst), .fire(upd_fire), .data_nxt(data_nxt),
    .inen_q(inen_q), .out_stb(out_stb), .out_level(out_level),
    .out_drive_en(out_drive_en)
  );

  gpio_port_sense #(.PINS(PINS)) i_sense (
    .clk(clk), .rst(rst), .pin_in(pin_in), .dir_q(dir_q), .inen_q(inen_q),
    .fer_q(fer_q), .in_level(in_level), .in_valid(in_valid)
  );

  // R7: a direction-clear write never produces an update strobe
  p_dirclr_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && bus_wr && bus_addr == OFS_OCLR) |=> !out_stb);

  // R7: a valid plain data write shows up on the output pins next cycle
  p_data_out_r7: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && bus_wr && bus_addr == OFS_DATA && !bus_size) |=>
      (out_stb && out_level == $past(bus_wdata[PINS-1:0])));

endmodule

// File: tb/test_gpio_port_ctrl.sv
`timescale 1ns/1ps
module test_gpio_port_ctrl;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic        bus_size = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_err;
  logic [15:0] pin_in = '0;
  logic        out_stb;
  logic [15:0] out_level, out_drive_en, in_level, in_valid;

  always #2.5 clk = ~clk;

  gpio_port_ctrl i_gpio_port_ctrl (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_err(bus_err), .pin_in(pin_in),
    .out_stb(out_stb), .out_level(out_level), .out_drive_en(out_drive_en),
    .in_level(in_level), .in_valid(in_valid)
  );

  typedef struct {
    int          kind;   // 0 bus response, 1 output update, 2 input forward
    string       req;
    logic [31:0] e0, e1, e2;
    int          due;
  } item_t;

  item_t sb[$];
  int cyc = 0;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // reference model state
  logic [15:0] m_fer = '0, m_data = '0, m_dir = '0, m_inen = '0;
  logic [31:0] m_mux = '0;
  logic [15:0] m_prev = '0, m_lvl = '0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic cmp(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // monitor: pops expected items when they fall due
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due <= cyc) begin
      item_t it;
      it = sb.pop_front();
      case (it.kind)
        0: begin
          cmp(it.req, "bus_rdata", bus_rdata, it.e0);
          cmp(it.req, "bus_err", {31'd0, bus_err}, it.e1);
        end
        1: begin
          cmp(it.req, "out_stb", {31'd0, out_stb}, it.e0);
          if (it.e0[0]) begin
            cmp(it.req, "out_level", {16'd0, out_level}, it.e1);
            cmp(it.req, "out_drive_en", {16'd0, out_drive_en}, it.e2);
          end
        end
        default: begin
          cmp(it.req, "in_valid", {16'd0, in_valid}, it.e0);
          cmp(it.req, "in_level", {16'd0, in_level}, it.e1);
        end
      endcase
    end
  end

  task automatic push(int kind, string req, logic [31:0] a, logic [31:0] b, logic [31:0] c);
    item_t it;
    it.kind = kind; it.req = req; it.e0 = a; it.e1 = b; it.e2 = c; it.due = cyc + 1;
    sb.push_back(it);
  endtask

  // driver: one bus access, expected results computed from the model
  task automatic acc(bit wr, logic [5:0] a, bit sz, logic [31:0] wd, string req);
    logic [2:0]  idx;
    bit          ok, stb;
    logic [31:0] rd;
    idx = a[4:2];
    ok  = (a[1:0] == 2'b00) && !a[5] && ((idx == 3'd7) ? sz : !sz);
    rd  = '0;
    if (ok && !wr) begin
      case (idx)
        3'd0: rd = {16'd0, m_fer};
        3'd1, 3'd2, 3'd3: rd = {16'd0, m_data};
        3'd4, 3'd5: rd = {16'd0, m_dir};
        3'd6: rd = {16'd0, m_inen};
        default: rd = m_mux;
      endcase
    end
    stb = wr && ok && (idx >= 3'd1) && (idx <= 3'd4);
    if (wr && ok) begin
      case (idx)
        3'd0: m_fer  = wd[15:0];
        3'd1: m_data = wd[15:0];
        3'd2: m_data = m_data | wd[15:0];
        3'd3: m_data = m_data & ~wd[15:0];
        3'd4: m_dir  = m_dir | wd[15:0];
        3'd5: m_dir  = m_dir & ~wd[15:0];
        3'd6: m_inen = wd[15:0];
        default: m_mux = wd;
      endcase
    end
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = wr; bus_addr = a; bus_size = sz; bus_wdata = wd;
    push(0, req, rd, {31'd0, !ok}, '0);
    push(1, req, {31'd0, stb}, {16'd0, m_data}, {16'd0, ~m_inen});
    @(posedge clk);
    #1 bus_sel = 1'b0;
  endtask

  task automatic pins(logic [15:0] v, string req);
    logic [15:0] q, hit;
    q   = ~m_dir & m_inen & m_fer;
    hit = (v ^ m_prev) & q;
    m_lvl  = (m_lvl & ~hit) | (v & hit);
    m_prev = v;
    @(negedge clk);
    pin_in = v;
    push(2, req, {16'd0, hit}, {16'd0, m_lvl}, '0);
    @(posedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R1: reset state at the ports
    cmp("R1", "outputs", {out_stb, bus_err, out_level, out_drive_en[13:0]}, '0);
    cmp("R1", "inputs side", {in_level, in_valid}, '0);
    for (int k = 0; k < 8; k++) acc(0, 6'(k * 4), (k == 7), '0, "R1");

    // R2: direct registers
    acc(1, 6'h00, 0, 32'h0000_00FF, "R2");
    acc(0, 6'h00, 0, '0, "R2");
    acc(1, 6'h18, 0, 32'h0000_0F0F, "R2");
    acc(0, 6'h18, 0, '0, "R2");
    acc(1, 6'h1C, 1, 32'hA5A5_5A5A, "R2");
    acc(0, 6'h1C, 1, '0, "R2");
    acc(1, 6'h04, 0, 32'hFFFF_1234, "R2 R7");
    acc(0, 6'h04, 0, '0, "R2");

    // R3: data set and clear aliases
    acc(1, 6'h08, 0, 32'h0000_8001, "R3 R7");
    acc(0, 6'h08, 0, '0, "R3");
    acc(1, 6'h0C, 0, 32'h0000_0030, "R3 R7");
    acc(0, 6'h0C, 0, '0, "R3");
    acc(0, 6'h04, 0, '0, "R3");

    // R4: direction through aliases only
    acc(1, 6'h10, 0, 32'h0000_00F0, "R4 R7");
    acc(0, 6'h14, 0, '0, "R4");
    acc(1, 6'h14, 0, 32'h0000_0030, "R4 R7 no strobe");
    acc(0, 6'h10, 0, '0, "R4");

    // R5: size errors change nothing
    acc(1, 6'h04, 1, 32'h0000_0000, "R5");
    acc(0, 6'h1C, 0, '0, "R5");
    acc(1, 6'h1C, 0, 32'h1111_1111, "R5");
    acc(0, 6'h1C, 1, '0, "R5");
    acc(0, 6'h04, 0, '0, "R5");

    // R6: invalid offsets
    acc(1, 6'h20, 0, 32'h0000_FFFF, "R6");
    acc(0, 6'h06, 0, '0, "R6");
    acc(1, 6'h3C, 1, 32'hFFFF_FFFF, "R6");
    acc(0, 6'h04, 0, '0, "R6");
    acc(0, 6'h1C, 1, '0, "R6");

    // R8 R9: input qualification (qualified mask now 0x000F)
    pins(16'hFFFF, "R8 R9");
    pins(16'hFFFF, "R8 steady");
    pins(16'h0000, "R8 R9");
    acc(1, 6'h14, 0, 32'h0000_FFFF, "R4");
    acc(1, 6'h18, 0, 32'h0000_FFFF, "R2");
    pins(16'h0F0F, "R8 R9");
    acc(1, 6'h00, 0, 32'h0000_F000, "R2");
    acc(1, 6'h10, 0, 32'h0000_4000, "R4 R7");
    pins(16'hF0F0, "R8 R9");
    acc(1, 6'h18, 0, 32'h0000_0000, "R2");
    pins(16'h0000, "R9");
    // R7: drive enable follows input enable on next update
    acc(1, 6'h04, 0, 32'h0000_5A5A, "R7");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule